// File: doc/BRIEF.md
# Processor Bus Master Transaction Engine

This block is a bus master for a processor-side bus that has separate outbound and inbound data paths. It carries out one transaction at a time. A request gives a 4-bit command code, an address, one data word, an expected fault value, a mode value and a byte-select pattern. For write commands the data word is sent to the slave. For read commands it is the value the slave is expected to return. The engine latches the request, then runs a fixed cycle of four clocks. The command code is held on the bus for the whole cycle. The address goes out first, followed by the write data where the command has any.

In the last clock of the cycle the engine samples the slave's reject and fault lines. A reject sends the engine back to the first phase, and the whole transaction is issued again with the same contents. A fault with an unexpected code, or returned read data that differs from the expected word, sets a sticky error flag. That flag stays set until the next request is accepted. A one-clock done pulse marks completion.

The state machine has five states. ST_IDLE waits for a request. ST_PH0 and ST_PH1 are the address phases, ST_PH2 is the data phase and ST_PH3 is the sample phase. The transitions are:
- accept: ST_IDLE to ST_PH0, when a request is valid.
- advance: ST_PH0 to ST_PH1, ST_PH1 to ST_PH2, and ST_PH2 to ST_PH3, always.
- retry: ST_PH3 to ST_PH0, when reject is high.
- finish: ST_PH3 to ST_IDLE, when reject is low.

Top module: `pbm_engine`

## Requirements
- R1: While busy, `bus_cmd` carries the 4-bit code latched at accept. The codes are: read 8, write 9, conditional-write-single 10, demap 11, IO read 12, IO write 13, clear-virtual-page 14 and broadcast IO write 15. In ST_IDLE, `bus_cmd` and `bus_dout` are 0.
- R2: An accepted transaction moves through four phases, one per clock. `bus_cmd` stays unchanged across all four phases and across retries.
- R3: In phases 0 and 1, `bus_dout` carries the latched address. For clear-virtual-page (14) it carries zero instead.
- R4: For write (9), IO write (13) and broadcast IO write (15), `bus_dout` carries the latched data in phases 2 and 3. The other commands keep the address on `bus_dout` in phase 2, with zero for command 14.
- R5: In phase 3, demap (11) and clear-virtual-page (14) drive zero on `bus_dout`. The remaining non-write commands keep the address there.
- R6: In phase 3, when `bus_reject` is high, the engine returns to phase 0 and reissues the transaction. When it is low, the transaction completes, and `done` is high for exactly the following clock.
- R7: On a completing phase 3, read (8), IO read (12) and conditional-write-single (10) compare `bus_din` with the latched expected word. A mismatch sets `err_data`. Phase 3 samples that are rejected are never compared.
- R8: In every phase 3, including rejected ones, when `bus_fault` is high the engine forms an observed value of 16 + `bus_fault_code`. If that value differs from the latched 5-bit expected fault value, `err_fault` is set. An expected value of 0 means no fault is expected. When `bus_fault` is low, no fault check is made.
- R9: `err_data` and `err_fault` are both 0 after reset. Once set, each stays set until the next accepted request, and accepting a request clears them.
- R10: `bus_user` is 0 (kernel) when the latched mode value is 0, and 1 (user) otherwise. `bus_bsel` carries the latched byte-select pattern. After reset, `bus_user` is 0 and `bus_bsel` is 0xF (full word).
- R11: `req_ready` is high only in ST_IDLE. A `req_valid` pulse while the engine is busy has no effect. A request that is valid during the done clock is accepted straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_cmd | input | 4 | Command code |
| req_addr | input | DATA_W | Address |
| req_data | input | DATA_W | Write data, or expected read data |
| req_fault_exp | input | FAULT_W+1 | Expected fault value (0 = none) |
| req_mode | input | MODE_W | Mode value (0 = kernel) |
| req_bsel | input | BSEL_W | Byte-select pattern |
| bus_cmd | output | 4 | Command on the bus |
| bus_dout | output | DATA_W | Outbound data path |
| bus_din | input | DATA_W | Inbound data path |
| bus_reject | input | 1 | Slave rejects, retry |
| bus_fault | input | 1 | Slave reports a fault |
| bus_fault_code | input | FAULT_W | Fault code |
| bus_user | output | 1 | 1 = user mode, 0 = kernel |
| bus_bsel | output | BSEL_W | Byte select |
| done | output | 1 | One-clock completion pulse |
| err_data | output | 1 | Sticky read-compare mismatch |
| err_fault | output | 1 | Sticky fault mismatch |

## Verification
Two pairs of functions can fall in the same clock. In the first pair, a phase 3 carries both a reject and a fault: the fault check must still update `err_fault` while the engine retries. The bench provokes this with a broadcast IO write whose slave rejects once while faulting with an unexpected code. It also issues a read whose rejected attempt returns wrong data, and that wrong data must not raise `err_data`. In the second pair, the done clock coincides with a new accept: the bench holds `req_valid` through a completion, and the reference model checks two things in that clock. The finished transaction's flags must be visible, and the next transaction must start in phase 0 on the following clock with its flags cleared.

// File: rtl/pbm_pkg.sv
`timescale 1ns/1ps
package pbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PH0,
        ST_PH1,
        ST_PH2,
        ST_PH3
    } pbm_state_e;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_RD    = 4'd8;
    localparam logic [CMD_W-1:0] CMD_WR    = 4'd9;
    localparam logic [CMD_W-1:0] CMD_CWS   = 4'd10;
    localparam logic [CMD_W-1:0] CMD_DEMAP = 4'd11;
    localparam logic [CMD_W-1:0] CMD_IORD  = 4'd12;
    localparam logic [CMD_W-1:0] CMD_IOWR  = 4'd13;
    localparam logic [CMD_W-1:0] CMD_CVP   = 4'd14;
    localparam logic [CMD_W-1:0] CMD_BIOWR = 4'd15;

    // Commands that send a data word in phases 2 and 3.
    function automatic logic cmd_sends_data(input logic [CMD_W-1:0] c);
        return (c == CMD_WR) || (c == CMD_IOWR) || (c == CMD_BIOWR);
    endfunction

    // Commands that compare returned data with the expected word.
    function automatic logic cmd_compares(input logic [CMD_W-1:0] c);
        return (c == CMD_RD) || (c == CMD_IORD) || (c == CMD_CWS);
    endfunction

    // Commands that carry no address.
    function automatic logic cmd_no_addr(input logic [CMD_W-1:0] c);
        return c == CMD_CVP;
    endfunction

    // Commands that drive zero in the sample phase.
    function automatic logic cmd_zero_tail(input logic [CMD_W-1:0] c);
        return (c == CMD_DEMAP) || (c == CMD_CVP);
    endfunction

endpackage

// File: rtl/pbm_seq.sv
`timescale 1ns/1ps
module pbm_seq
    import pbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       reject,
    output pbm_state_e state,
    output logic       done
);

    pbm_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_PH3) && !reject;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_PH0;
            ST_PH0:  state_nx = ST_PH1;
            ST_PH1:  state_nx = ST_PH2;
            ST_PH2:  state_nx = ST_PH3;
            ST_PH3:  state_nx = reject ? ST_PH0 : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    AST_RETRY_TO_PH0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH3 && reject) |=> (state == ST_PH0 && !done)); // R6

    AST_DONE_AFTER_PH3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_PH3 && state == ST_IDLE)); // R6

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH1) |=> (state == ST_PH2)); // R2

endmodule

// File: rtl/pbm_drive.sv
`timescale 1ns/1ps
module pbm_drive
    import pbm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pbm_state_e            state,
    input  logic [CMD_W-1:0]      cmd,
    input  logic [DATA_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [CMD_W-1:0]      bus_cmd,
    output logic [DATA_W-1:0]     bus_dout
);

    logic [DATA_W-1:0] addr_word;

    assign addr_word = cmd_no_addr(cmd) ? '0 : addr;

    always_comb begin
        bus_cmd  = cmd;
        bus_dout = addr_word;
        unique case (state)
            ST_IDLE: begin
                bus_cmd  = '0;
                bus_dout = '0;
            end
            ST_PH0, ST_PH1: bus_dout = addr_word;
            ST_PH2: bus_dout = cmd_sends_data(cmd) ? wdata : addr_word;
            ST_PH3: begin
                if (cmd_sends_data(cmd))     bus_dout = wdata;
                else if (cmd_zero_tail(cmd)) bus_dout = '0;
                else                         bus_dout = addr;
            end
            default: begin
                bus_cmd  = '0;
                bus_dout = '0;
            end
        endcase
    end

    AST_CVP_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cmd == CMD_CVP) |-> (bus_dout == '0)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (bus_cmd == '0 && bus_dout == '0)); // R1

endmodule

// File: rtl/pbm_check.sv
`timescale 1ns/1ps
module pbm_check
    import pbm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FAULT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  pbm_state_e         state,
    input  logic               reject,
    input  logic [CMD_W-1:0]   cmd,
    input  logic [DATA_W-1:0]  din,
    input  logic [DATA_W-1:0]  exp_data,
    input  logic               fault,
    input  logic [FAULT_W-1:0] fault_code,
    input  logic [FAULT_W:0]   exp_fault,
    output logic               err_data,
    output logic               err_fault
);

    logic [FAULT_W:0] fault_seen;
    logic             sample;

    assign fault_seen = {1'b1, fault_code};
    assign sample     = (state == ST_PH3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_data  <= 1'b0;
            err_fault <= 1'b0;
        end else if (start) begin
            err_data  <= 1'b0;
            err_fault <= 1'b0;
        end else if (sample) begin
            if (fault && fault_seen != exp_fault)
                err_fault <= 1'b1;
            if (!reject && cmd_compares(cmd) && din != exp_data)
                err_data <= 1'b1;
        end
    end

    AST_FLAGS_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!err_data && !err_fault)); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !start) |=> ($stable(err_data) && $stable(err_fault))); // R9

    AST_NO_COMPARE_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && reject && !err_data) |=> !err_data); // R7

endmodule

// File: rtl/pbm_engine.sv
`timescale 1ns/1ps
module pbm_engine
    import pbm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FAULT_W = 4,
    parameter int MODE_W  = 2,
    parameter int BSEL_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [3:0]         req_cmd,
    input  logic [DATA_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [FAULT_W:0]   req_fault_exp,
    input  logic [MODE_W-1:0]  req_mode,
    input  logic [BSEL_W-1:0]  req_bsel,
    output logic [3:0]         bus_cmd,
    output logic [DATA_W-1:0]  bus_dout,
    input  logic [DATA_W-1:0]  bus_din,
    input  logic               bus_reject,
    input  logic               bus_fault,
    input  logic [FAULT_W-1:0] bus_fault_code,
    output logic               bus_user,
    output logic [BSEL_W-1:0]  bus_bsel,
    output logic               done,
    output logic               err_data,
    output logic               err_fault
);

    localparam logic [BSEL_W-1:0] BSEL_FULL = '1;

    pbm_state_e         state;
    logic               start;
    logic [CMD_W-1:0]   lat_cmd;
    logic [DATA_W-1:0]  lat_addr;
    logic [DATA_W-1:0]  lat_data;
    logic [FAULT_W:0]   lat_fault;
    logic               lat_user;
    logic [BSEL_W-1:0]  lat_bsel;

    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid && req_ready;
    assign bus_user  = lat_user;
    assign bus_bsel  = lat_bsel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cmd   <= '0;
            lat_addr  <= '0;
            lat_data  <= '0;
            lat_fault <= '0;
            lat_user  <= 1'b0;
            lat_bsel  <= BSEL_FULL;
        end else if (start) begin
            lat_cmd   <= req_cmd;
            lat_addr  <= req_addr;
            lat_data  <= req_data;
            lat_fault <= req_fault_exp;
            lat_user  <= (req_mode != '0);
            lat_bsel  <= req_bsel;
        end
    end

    pbm_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .reject (bus_reject),
        .state  (state),
        .done   (done)
    );

    pbm_drive #(.DATA_W(DATA_W)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .cmd      (lat_cmd),
        .addr     (lat_addr),
        .wdata    (lat_data),
        .bus_cmd  (bus_cmd),
        .bus_dout (bus_dout)
    );

    pbm_check #(.DATA_W(DATA_W), .FAULT_W(FAULT_W)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .state      (state),
        .reject     (bus_reject),
        .cmd        (lat_cmd),
        .din        (bus_din),
        .exp_data   (lat_data),
        .fault      (bus_fault),
        .fault_code (bus_fault_code),
        .exp_fault  (lat_fault),
        .err_data   (err_data),
        .err_fault  (err_fault)
    );

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !(state == ST_PH3 && !bus_reject)) |=> $stable(bus_cmd)); // R2

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready) |=> ($stable(bus_user) && $stable(bus_bsel))); // R11

endmodule

// File: tb/pbm_engine_bench.sv
`timescale 1ns/1ps
module pbm_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [4:0]  req_fault_exp = '0;
    logic [1:0]  req_mode = '0;
    logic [3:0]  req_bsel = '0;
    logic [3:0]  bus_cmd;
    logic [31:0] bus_dout;
    logic [31:0] bus_din = '0;
    logic        bus_reject = 1'b0;
    logic        bus_fault = 1'b0;
    logic [3:0]  bus_fault_code = '0;
    logic        bus_user;
    logic [3:0]  bus_bsel;
    logic        done;
    logic        err_data;
    logic        err_fault;

    always #2.5 clk = ~clk;

    pbm_engine u_pbm_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_data(req_data),
        .req_fault_exp(req_fault_exp), .req_mode(req_mode), .req_bsel(req_bsel),
        .bus_cmd(bus_cmd), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_reject(bus_reject), .bus_fault(bus_fault), .bus_fault_code(bus_fault_code),
        .bus_user(bus_user), .bus_bsel(bus_bsel), .done(done),
        .err_data(err_data), .err_fault(err_fault)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int          m_phase = -1;
    int          m_cmd = 0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_data = '0;
    int          m_fexp = 0;
    bit          m_user = 0;
    logic [3:0]  m_bsel = 4'hF;
    bit          m_done = 0;
    bit          m_errd = 0;
    bit          m_errf = 0;

    // responder settings
    int          rej_left = 0;
    bit          r_fault = 0;
    logic [3:0]  r_code = '0;
    logic [31:0] r_din = '0;
    logic [31:0] r_din_rej = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_dout();
        bit wr;
        wr = (m_cmd == 9) || (m_cmd == 13) || (m_cmd == 15);
        if (m_phase < 0) return 32'h0;
        if (m_phase >= 2 && wr) return m_data;
        if (m_cmd == 14) return 32'h0;
        if (m_phase == 3 && m_cmd == 11) return 32'h0;
        return m_addr;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = -1; m_done = 0; m_errd = 0; m_errf = 0;
            m_user = 0; m_bsel = 4'hF; m_cmd = 0; m_addr = '0; m_data = '0;
        end else begin
            m_done = 0;
            if (m_phase < 0) begin
                if (req_valid) begin
                    m_cmd = int'(req_cmd); m_addr = req_addr; m_data = req_data;
                    m_fexp = int'(req_fault_exp); m_user = (req_mode != 0);
                    m_bsel = req_bsel; m_errd = 0; m_errf = 0; m_phase = 0;
                end
            end else if (m_phase < 3) begin
                m_phase = m_phase + 1;
            end else begin
                if (bus_fault && (16 + int'(bus_fault_code)) != m_fexp) m_errf = 1;
                if (bus_reject) m_phase = 0;
                else begin
                    if ((m_cmd == 8 || m_cmd == 12 || m_cmd == 10) && bus_din != m_data)
                        m_errd = 1;
                    m_phase = -1;
                    m_done = 1;
                end
            end
        end
    end

    // per-clock comparison and slave responder
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 bus_cmd", bus_cmd, (m_phase < 0) ? 0 : m_cmd);
            chk("R3/R4/R5 bus_dout", bus_dout, exp_dout());
            chk("R6 done", done, m_done);
            chk("R11 req_ready", req_ready, m_phase < 0);
            chk("R7 err_data", err_data, m_errd);
            chk("R8 err_fault", err_fault, m_errf);
            chk("R10 bus_user", bus_user, m_user);
            chk("R10 bus_bsel", bus_bsel, m_bsel);
            if (m_phase == 3) begin
                bus_reject     = (rej_left > 0);
                bus_din        = (rej_left > 0) ? r_din_rej : r_din;
                if (rej_left > 0) rej_left--;
                bus_fault      = r_fault;
                bus_fault_code = r_code;
            end else begin
                bus_reject = 0;
                bus_fault  = 0;
                bus_din    = '0;
            end
        end
    end

    task automatic txn(input logic [3:0] c, input logic [31:0] a, input logic [31:0] d,
                       input logic [4:0] ef, input logic [1:0] m, input logic [3:0] b,
                       input int rj, input bit fo, input logic [3:0] fc,
                       input logic [31:0] rdin, input logic [31:0] rdin_bad, input bit poke);
        rej_left = rj; r_fault = fo; r_code = fc; r_din = rdin; r_din_rej = rdin_bad;
        req_cmd = c; req_addr = a; req_data = d; req_fault_exp = ef;
        req_mode = m; req_bsel = b; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            // R11: a request while busy must be ignored
            @(negedge clk);
            req_valid = 1; req_cmd = 4'd9; req_addr = ~a; req_mode = ~m; req_bsel = ~b;
            @(negedge clk);
            req_valid = 0;
        end
        do @(negedge clk); while (!m_done);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        finished = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: R9, R10, R1
        chk("R9 reset err_data", err_data, 0);
        chk("R9 reset err_fault", err_fault, 0);
        chk("R10 reset bus_bsel", bus_bsel, 4'hF);
        chk("R10 reset bus_user", bus_user, 0);
        chk("R1 reset bus_cmd", bus_cmd, 0);
        rst_n = 1;
        @(negedge clk);

        // R4 write, R10 user mode
        txn(4'd9, 32'h0000_0100, 32'hDEAD_BEEF, 0, 2'd1, 4'h3, 0, 0, 0, 0, 0, 0);
        // R7 read match
        txn(4'd8, 32'h0000_0200, 32'h1234_5678, 0, 2'd0, 4'hF, 0, 0, 0, 32'h1234_5678, 0, 0);
        // R7 read mismatch
        txn(4'd8, 32'h0000_0204, 32'h1111_1111, 0, 2'd0, 4'hF, 0, 0, 0, 32'h2222_2222, 0, 0);
        chk("R7 mismatch flagged", err_data, 1);
        // R9 flags cleared by the next accept; R6 two rejects; IO read
        txn(4'd12, 32'h0000_0300, 32'hCAFE_0001, 0, 2'd2, 4'h1, 2, 0, 0, 32'hCAFE_0001, 32'h0, 0);
        chk("R9 cleared on accept", err_data, 0);
        // R7 rejected attempt with wrong data is not compared
        txn(4'd8, 32'h0000_0400, 32'hAAAA_5555, 0, 2'd0, 4'hF, 1, 0, 0, 32'hAAAA_5555, 32'h0BAD_0BAD, 0);
        chk("R7 no compare on reject", err_data, 0);
        // R8 expected fault 16+3=19, with one reject
        txn(4'd13, 32'h0000_0500, 32'h0F0F_0F0F, 5'd19, 2'd0, 4'hF, 1, 1, 4'd3, 0, 0, 0);
        chk("R8 matching fault", err_fault, 0);
        // R8 unexpected fault on rejected attempt of broadcast IO write
        txn(4'd15, 32'h0000_0600, 32'h5A5A_5A5A, 5'd0, 2'd0, 4'hF, 1, 1, 4'd5, 0, 0, 0);
        chk("R8 unexpected fault", err_fault, 1);
        // R5 demap, R3 clear-virtual-page, R7 conditional-write-single mismatch
        txn(4'd11, 32'h0000_0700, 32'h0, 0, 2'd0, 4'hF, 0, 0, 0, 0, 0, 0);
        txn(4'd14, 32'h0000_0800, 32'h0, 0, 2'd0, 4'hF, 1, 0, 0, 0, 0, 0);
        txn(4'd10, 32'h0000_0900, 32'h7777_7777, 0, 2'd3, 4'h8, 0, 0, 0, 32'h7777_7770, 0, 0);
        chk("R7 cws mismatch", err_data, 1);
        // R11 busy poke ignored
        txn(4'd12, 32'h0000_0A00, 32'h0000_00A0, 0, 2'd1, 4'h6, 1, 0, 0, 32'h0000_00A0, 0, 1);
        chk("R11 poke ignored bsel", bus_bsel, 4'h6);

        // R11 back-to-back: request held valid through done
        rej_left = 0; r_fault = 0; r_din = 32'h0; r_din_rej = 32'h0;
        req_cmd = 4'd8; req_addr = 32'h0000_0B00; req_data = 32'h0000_0001;
        req_fault_exp = 0; req_mode = 0; req_bsel = 4'hF; req_valid = 1;
        do @(negedge clk); while (!m_done);
        chk("R7 first of pair mismatch", err_data, 1);
        req_cmd = 4'd9; req_addr = 32'h0000_0C00; req_data = 32'h0000_0C0C; req_mode = 2'd1;
        @(negedge clk);
        req_valid = 0;
        chk("R11 second accepted", bus_cmd, 4'd9);
        chk("R9 cleared for second", err_data, 0);
        do @(negedge clk); while (!m_done);
        @(negedge clk);

        finished = 1;
        finish_run();
    end

endmodule